// File: doc/BRIEF.md
# Timer compare channel reference generator

This block forms one compare channel of a general-purpose timer. Each clock it reads the current counter value, the counting direction, the channel's compare value and a 3-bit mode code. From these it produces the channel's reference level. That level then goes to later output stages, such as polarity and dead-time logic, which are not part of this block. The modes are:

- keep the current level;
- drive high, drive low or toggle when the counter equals the compare value;
- force the level low or high, whatever the compare result;
- two pulse-width modes that depend on the counting direction.

An external clear input, when its enable bit is set, pulls the reference low. The clear is then held in a latch, so the reference stays low until the next update-event pulse, even if the clear input drops earlier.

All inputs are plain control signals sampled on every rising clock edge. The block has no valid/ready streams, so it never applies back-pressure. The output is registered. A change on the inputs before an edge appears on `ref_out` just after that edge. Reset is synchronous and active-low.

Top module: `cmp_chan_ref`

## Requirements
- R1: While `rst_n` is low at a rising edge, `ref_out` becomes 0 and the mode level and the clear latch become 0.
- R2: With mode 3'b110 and `cnt_down`=0, `ref_out` after the edge is 1 exactly when `cnt_val` < `cmp_val`.
- R3: With mode 3'b110 and `cnt_down`=1, `ref_out` after the edge is 1 exactly when `cnt_val` <= `cmp_val`.
- R4: With mode 3'b111, `ref_out` is the inverse of what mode 3'b110 would give for the same counter, direction and compare value.
- R5: Mode 3'b100 drives `ref_out` to 0 and mode 3'b101 drives it to 1, whatever the compare result.
- R6: Mode 3'b000 keeps the current level unchanged, whatever the counter and compare values.
- R7: Mode 3'b001 sets the level to 1 on a cycle where `cnt_val` == `cmp_val`. Mode 3'b010 clears it to 0 on such a cycle. Otherwise the level is kept.
- R8: Mode 3'b011 inverts the level on every cycle where `cnt_val` == `cmp_val`, and keeps it otherwise.
- R9: When `clr_en`=1 and `ext_clr`=1 at an edge, `ref_out` is 0 after that edge.
- R10: After a clear, `ref_out` stays 0 until an edge where `upd_evt`=1 and no clear is active. From that edge the mode level shows again.
- R11: When `clr_en`=0, `ext_clr` has no effect on `ref_out`.
- R12: In mode 3'b110 counting up, `cmp_val`=0 gives a constant 0. A `cmp_val` above every value the counter reaches gives a constant 1.
- R13: The mode level keeps advancing while a clear holds the output low. After release, `ref_out` shows the level that the mode logic reached in the meantime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_val | input | CNT_W | Current counter value |
| cnt_down | input | 1 | 1 = counter counting down, 0 = up |
| cmp_val | input | CNT_W | Compare value |
| mode | input | 3 | Mode code: 000 keep, 001 set on match, 010 clear on match, 011 toggle on match, 100 force low, 101 force high, 110 pulse-width A, 111 pulse-width B |
| upd_evt | input | 1 | Update-event pulse; releases the clear latch |
| ext_clr | input | 1 | External clear request, active high |
| clr_en | input | 1 | Enables the external clear |
| ref_out | output | 1 | Registered channel reference level |

## Verification
The pulse-width modes are driven with counter sweeps in both directions past the compare value. This separates the strict from the inclusive comparison and shows that mode 3'b111 is the exact inverse of mode 3'b110. The compare values 0 and "above the sweep" show the constant outputs. Match-driven modes get repeated hits and misses, so that keeping, setting, clearing and toggling are each told apart from the others. Clear sequences drop `ext_clr` before and after an update pulse, raise it with the enable off, and toggle the mode level underneath. Together these separate a live clear from a latched one and show what the output returns to after release.

// File: rtl/cmp_chan_pkg.sv
package cmp_chan_pkg;
  typedef enum logic [2:0] {
    MODE_KEEP   = 3'b000,
    MODE_SET    = 3'b001,
    MODE_CLR    = 3'b010,
    MODE_TGL    = 3'b011,
    MODE_FLOW   = 3'b100,
    MODE_FHIGH  = 3'b101,
    MODE_PWA    = 3'b110,
    MODE_PWB    = 3'b111
  } chan_mode_t;
endpackage

// File: rtl/cmp_chan_compare.sv
module cmp_chan_compare #(
  parameter int CNT_W = 8
) (
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             cnt_down,
  output logic             hit,
  output logic             pw_high
);
  logic below;
  always_comb begin
    below   = (cnt_val < cmp_val);
    hit     = (cnt_val == cmp_val);
    // counting down the equal value still counts as inside the pulse
    pw_high = cnt_down ? (below | hit) : below;
  end
endmodule

// File: rtl/cmp_chan_level.sv
module cmp_chan_level
  import cmp_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  chan_mode_t mode,
  input  logic       hit,
  input  logic       pw_high,
  output logic       lvl_next,
  output logic       lvl_q
);
  always_comb begin
    lvl_next = lvl_q;
    unique case (mode)
      MODE_KEEP:  lvl_next = lvl_q;
      MODE_SET:   lvl_next = hit ? 1'b1 : lvl_q;
      MODE_CLR:   lvl_next = hit ? 1'b0 : lvl_q;
      MODE_TGL:   lvl_next = hit ? ~lvl_q : lvl_q;
      MODE_FLOW:  lvl_next = 1'b0;
      MODE_FHIGH: lvl_next = 1'b1;
      MODE_PWA:   lvl_next = pw_high;
      MODE_PWB:   lvl_next = ~pw_high;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) lvl_q <= 1'b0;
    else        lvl_q <= lvl_next;
  end

  assert_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_KEEP) |=> (lvl_q == $past(lvl_q)));
  assert_toggle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_TGL && hit) |=> (lvl_q != $past(lvl_q)));
endmodule

// File: rtl/cmp_chan_clrlatch.sv
module cmp_chan_clrlatch (
  input  logic clk,
  input  logic rst_n,
  input  logic ext_clr,
  input  logic clr_en,
  input  logic upd_evt,
  output logic hold_next,
  output logic hold_q
);
  logic clr_live;
  always_comb begin
    clr_live = clr_en & ext_clr;
    if (clr_live)     hold_next = 1'b1;
    else if (upd_evt) hold_next = 1'b0;
    else              hold_next = hold_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_next;
  end

  assert_latch_keeps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !upd_evt) |=> hold_q);
endmodule

// File: rtl/cmp_chan_ref.sv
module cmp_chan_ref
  import cmp_chan_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_down,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [2:0]       mode,
  input  logic             upd_evt,
  input  logic             ext_clr,
  input  logic             clr_en,
  output logic             ref_out
);
  chan_mode_t mode_e;
  logic hit, pw_high, lvl_next, lvl_q, hold_next, hold_q;

  assign mode_e = chan_mode_t'(mode);

  cmp_chan_compare #(.CNT_W(CNT_W)) u_cmp (
    .cnt_val(cnt_val), .cmp_val(cmp_val), .cnt_down(cnt_down),
    .hit(hit), .pw_high(pw_high)
  );

  cmp_chan_level u_lvl (
    .clk(clk), .rst_n(rst_n), .mode(mode_e), .hit(hit), .pw_high(pw_high),
    .lvl_next(lvl_next), .lvl_q(lvl_q)
  );

  cmp_chan_clrlatch u_clr (
    .clk(clk), .rst_n(rst_n), .ext_clr(ext_clr), .clr_en(clr_en),
    .upd_evt(upd_evt), .hold_next(hold_next), .hold_q(hold_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ref_out <= 1'b0;
    else        ref_out <= lvl_next & ~hold_next;
  end

  logic blocked;
  assign blocked = (clr_en & ext_clr) | (hold_q & ~upd_evt);

  assert_live_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && ext_clr) |=> !ref_out);
  assert_held_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_q && !upd_evt) |=> !ref_out);
  assert_force_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b100) |=> !ref_out);
  assert_force_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b101 && !blocked) |=> ref_out);
  assert_pw_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && !cnt_down && !blocked) |=> (ref_out == $past(cnt_val < cmp_val)));
  assert_pw_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b110 && cnt_down && !blocked) |=> (ref_out == $past(cnt_val <= cmp_val)));
  assert_pw_inv_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 3'b111 && !cnt_down && !blocked) |=> (ref_out == $past(cnt_val >= cmp_val)));
  assert_release_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!blocked) |=> (ref_out == lvl_q));
endmodule

// File: tb/cmp_chan_ref_test.sv
module cmp_chan_ref_test;
  localparam int W = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] cnt_val = '0, cmp_val = '0;
  logic cnt_down = 1'b0, upd_evt = 1'b0, ext_clr = 1'b0, clr_en = 1'b0;
  logic [2:0] mode = 3'b000;
  logic ref_out;

  int checks = 0, failures = 0;
  bit    exp_q[$];
  string tag_q[$];
  bit m_lvl = 1'b0, m_hold = 1'b0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  cmp_chan_ref #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_down(cnt_down),
    .cmp_val(cmp_val), .mode(mode), .upd_evt(upd_evt), .ext_clr(ext_clr),
    .clr_en(clr_en), .ref_out(ref_out)
  );

  // driver: apply one cycle of stimulus and push the expected output
  task automatic step(input bit rn, input int cv, input bit dn, input int cp,
                      input logic [2:0] md, input bit up, input bit xc,
                      input bit ce, input string tag);
    bit hit, pw, nl, nh;
    @(negedge clk);
    rst_n = rn; cnt_val = W'(cv); cnt_down = dn; cmp_val = W'(cp);
    mode = md; upd_evt = up; ext_clr = xc; clr_en = ce;
    hit = (cv == cp);
    pw  = dn ? (cv <= cp) : (cv < cp);
    case (md)
      3'b000: nl = m_lvl;
      3'b001: nl = hit ? 1'b1 : m_lvl;
      3'b010: nl = hit ? 1'b0 : m_lvl;
      3'b011: nl = hit ? ~m_lvl : m_lvl;
      3'b100: nl = 1'b0;
      3'b101: nl = 1'b1;
      3'b110: nl = pw;
      default: nl = ~pw;
    endcase
    nh = (ce && xc) ? 1'b1 : (up ? 1'b0 : m_hold);
    if (!rn) begin nl = 1'b0; nh = 1'b0; end
    m_lvl = nl; m_hold = nh;
    exp_q.push_back(nl & ~nh);
    tag_q.push_back(tag);
  endtask

  // monitor: compare after each rising edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (ref_out !== e) begin
        failures++;
        $display("FAIL %s: ref_out=%b expected=%b", t, ref_out, e);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1 reset
    repeat (3) step(0, 3, 0, 9, 3'b101, 0, 0, 0, "R1");
    // R2 pulse-width A, counting up
    for (int i = 0; i < 12; i++) step(1, i, 0, 5, 3'b110, 0, 0, 0, "R2");
    // R3 counting down
    for (int i = 11; i >= 0; i--) step(1, i, 1, 5, 3'b110, 0, 0, 0, "R3");
    // R4 pulse-width B, both directions
    for (int i = 0; i < 10; i++) step(1, i, 0, 4, 3'b111, 0, 0, 0, "R4");
    for (int i = 9; i >= 0; i--) step(1, i, 1, 4, 3'b111, 0, 0, 0, "R4");
    // R5 forced levels, with matches present
    step(1, 7, 0, 7, 3'b101, 0, 0, 0, "R5");
    step(1, 2, 0, 7, 3'b101, 0, 0, 0, "R5");
    step(1, 7, 0, 7, 3'b100, 0, 0, 0, "R5");
    step(1, 9, 1, 7, 3'b100, 0, 0, 0, "R5");
    // R6 keep level (currently 0), then from 1
    step(1, 7, 0, 7, 3'b000, 0, 0, 0, "R6");
    step(1, 1, 0, 7, 3'b101, 0, 0, 0, "R6");
    for (int i = 0; i < 4; i++) step(1, i * 3, 0, 3, 3'b000, 0, 0, 0, "R6");
    // R7 clear on match, then set on match
    step(1, 2, 0, 5, 3'b010, 0, 0, 0, "R7");
    step(1, 5, 0, 5, 3'b010, 0, 0, 0, "R7");
    step(1, 6, 0, 5, 3'b001, 0, 0, 0, "R7");
    step(1, 5, 0, 5, 3'b001, 0, 0, 0, "R7");
    step(1, 6, 0, 5, 3'b001, 0, 0, 0, "R7");
    // R8 toggle with hits and misses
    for (int i = 0; i < 8; i++) step(1, (i % 3 == 0) ? 4 : i, 0, 4, 3'b011, 0, 0, 0, "R8");
    // R9/R10 live clear then latched, released by update
    step(1, 0, 0, 9, 3'b101, 0, 0, 0, "R9");
    step(1, 0, 0, 9, 3'b101, 0, 1, 1, "R9");
    step(1, 0, 0, 9, 3'b101, 0, 0, 1, "R10");
    step(1, 0, 0, 9, 3'b101, 0, 0, 0, "R10");
    step(1, 0, 0, 9, 3'b101, 1, 1, 1, "R10");
    step(1, 0, 0, 9, 3'b101, 1, 0, 1, "R10");
    step(1, 0, 0, 9, 3'b101, 0, 0, 1, "R10");
    // R11 clear ignored when disabled
    step(1, 0, 0, 9, 3'b101, 0, 1, 0, "R11");
    step(1, 0, 0, 9, 3'b101, 0, 1, 0, "R11");
    step(1, 0, 0, 9, 3'b101, 1, 0, 0, "R11");
    // R13 toggle underneath a clear, then release
    step(1, 3, 0, 3, 3'b011, 0, 1, 1, "R13");
    step(1, 3, 0, 3, 3'b011, 0, 0, 0, "R13");
    step(1, 3, 0, 3, 3'b011, 0, 0, 0, "R13");
    step(1, 1, 0, 3, 3'b011, 1, 0, 0, "R13");
    step(1, 1, 0, 3, 3'b011, 0, 0, 0, "R13");
    // R12 constant outputs
    for (int i = 0; i < 10; i++) step(1, i * 15, 0, 0, 3'b110, 0, 0, 0, "R12");
    for (int i = 0; i < 10; i++) step(1, i * 15, 0, 200, 3'b110, 0, 0, 0, "R12");
    // R1 reset again from a high output
    step(0, 0, 0, 9, 3'b101, 0, 0, 0, "R1");
    step(1, 0, 0, 9, 3'b000, 0, 0, 0, "R1");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule